// File: doc/BRIEF.md
# Mask-to-Lane-Sign Expander with Bitplane Packer

The block spreads a 16-bit mask across the byte lanes of a 128-bit vector: each mask bit lands in the most significant bit of its own byte lane. In the default mode the other seven bits of every lane pass through unchanged. A second mode fills each lane completely, giving 0xFF for a set mask bit and 0x00 for a clear one, which is the form compare results take. This single operation is purely combinational.

Built on the same expansion primitive is a sequencer that rebuilds packed 8-bit pixels from eight bitplanes. A start pulse clears an internal set of eight byte lanes. Each accepted plane byte is written into the lane sign bits, with bit j going to lane j. Every lane is then shifted right by one bit, with zero fill and no bit crossing into a neighbouring lane. After the eighth plane the shift is skipped. Plane k therefore ends in bit k of every pixel, and a one-cycle done pulse marks the result.

Top module: `sign_plane_unit`

## Requirements
- R1: On the operation port, bit i of `op_mask` appears at bit 8*i+7 of `op_vec_out` for every lane i from 0 to 15, in both modes.
- R2: With `op_fill` = 0, bits 8*i+6 down to 8*i of `op_vec_out` equal the same bits of `op_vec_in`.
- R3: With `op_fill` = 1, lane i of `op_vec_out` is 0xFF when mask bit i is 1 and 0x00 when it is 0, whatever `op_vec_in` holds.
- R4: After reset, and in the cycle after `pl_start`, `pl_pixels` reads all zero.
- R5: After eight accepted plane bytes P0..P7, in that order, bit k of pixel lane j (`pl_pixels[8*j+k]`) equals bit j of Pk.
- R6: A cycle with `pl_valid` low consumes no plane, so idle gaps between plane bytes do not change the result.
- R7: `pl_done` is high for exactly one cycle: the cycle after the eighth plane byte is accepted.
- R8: After completion, `pl_pixels` stays unchanged until the next `pl_start`. Plane bytes offered in that period are ignored.
- R9: `pl_start` restarts a conversion at any time, including mid-conversion. A `pl_valid` in the same cycle as `pl_start` is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_mask | input | 16 | One bit per byte lane for the single operation |
| op_vec_in | input | 128 | Vector whose low lane bits are kept in mode 0 |
| op_fill | input | 1 | 0: replace only the sign bit; 1: fill the whole lane |
| op_vec_out | output | 128 | Result of the single operation (combinational) |
| pl_start | input | 1 | Clear the pixel lanes and begin a new conversion |
| pl_valid | input | 1 | A plane byte is presented on `pl_byte` |
| pl_byte | input | 8 | Plane byte; bit j belongs to pixel lane j |
| pl_done | output | 1 | One-cycle pulse once the eighth plane is taken |
| pl_pixels | output | 64 | Eight packed pixels; pixel j in bits 8*j+7..8*j |

## Verification
A wrong step count shifts every pixel by whole bit positions. It also moves `pl_done` off its cycle. Both show at the ports in the cycle right after the eighth plane byte. A lane shift that crosses lane boundaries, or a wrong insert/shift order, corrupts specific bit positions of the packed pixels. Randomly chosen plane sets, compared with a transpose computed in the bench, expose this at the end of each conversion. Stale lane contents or a missed hold show as nonzero pixels right after start, or as pixels that change during the idle period after done.

// File: rtl/sign_plane_pkg.sv
package sign_plane_pkg;
   typedef enum logic {
      FILL_SIGN_ONLY = 1'b0,
      FILL_WHOLE     = 1'b1
   } fill_mode_e;

   localparam int unsigned DEF_LANES     = 16;
   localparam int unsigned DEF_LANE_W    = 8;
   localparam int unsigned DEF_PIX_LANES = 8;
endpackage

// File: rtl/lane_sign_expand.sv
module lane_sign_expand
   import sign_plane_pkg::*;
#(
   parameter int unsigned LANES  = DEF_LANES,
   parameter int unsigned LANE_W = DEF_LANE_W,
   localparam int unsigned VEC_W = LANES * LANE_W
) (
   input  logic [LANES-1:0] mask,
   input  logic [VEC_W-1:0] vec_in,
   input  fill_mode_e       mode,
   output logic [VEC_W-1:0] vec_out
);
   if (LANE_W < 2) begin : g_bad_width
      $error("lane_sign_expand: LANE_W must be at least 2");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] lane_in;
      logic [LANE_W-1:0] lane_out;
      assign lane_in = vec_in[i*LANE_W +: LANE_W];
      always_comb begin
         if (mode == FILL_WHOLE) begin
            lane_out = {LANE_W{mask[i]}};
         end else begin
            lane_out = {mask[i], lane_in[LANE_W-2:0]};
         end
      end
      assign vec_out[i*LANE_W +: LANE_W] = lane_out;
   end
endmodule

// File: rtl/lane_shift_right.sv
module lane_shift_right #(
   parameter int unsigned LANES  = 8,
   parameter int unsigned LANE_W = 8,
   localparam int unsigned VEC_W = LANES * LANE_W
) (
   input  logic [VEC_W-1:0] vec_in,
   output logic [VEC_W-1:0] vec_out
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign vec_out[i*LANE_W +: LANE_W] = {1'b0, vec_in[i*LANE_W+1 +: LANE_W-1]};
   end
endmodule

// File: rtl/planar_packer.sv
module planar_packer
   import sign_plane_pkg::*;
#(
   parameter int unsigned PIX_LANES = DEF_PIX_LANES,
   parameter int unsigned LANE_W    = DEF_LANE_W,
   localparam int unsigned PLANES   = LANE_W,
   localparam int unsigned PIX_W    = PIX_LANES * LANE_W,
   localparam int unsigned CNT_W    = (PLANES > 1) ? $clog2(PLANES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 valid,
   input  logic [PIX_LANES-1:0] plane,
   output logic                 done,
   output logic [PIX_W-1:0]     pixels
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PLANES - 1);

   if (PLANES < 2) begin : g_bad_planes
      $error("planar_packer: need at least two planes");
   end

   logic [PIX_W-1:0] acc;
   logic [PIX_W-1:0] inserted;
   logic [PIX_W-1:0] shifted;
   logic [CNT_W-1:0] step;
   logic             busy;
   logic             take;

   lane_sign_expand #(
      .LANES  (PIX_LANES),
      .LANE_W (LANE_W)
   ) u_insert (
      .mask    (plane),
      .vec_in  (acc),
      .mode    (FILL_SIGN_ONLY),
      .vec_out (inserted)
   );

   lane_shift_right #(
      .LANES  (PIX_LANES),
      .LANE_W (LANE_W)
   ) u_shift (
      .vec_in  (inserted),
      .vec_out (shifted)
   );

   assign take = busy && valid && !start;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc  <= '0;
         step <= '0;
         busy <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            acc  <= '0;
            step <= '0;
            busy <= 1'b1;
         end else if (take) begin
            if (step == LAST) begin
               acc  <= inserted;
               step <= '0;
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               acc  <= shifted;
               step <= step + 1'b1;
            end
         end
      end
   end

   assign pixels = acc;

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && step == LAST) |=> (done && !busy));

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !take) |=> $stable(acc));

   assert_clear_on_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (acc == '0 && busy && step == '0));

   assert_no_take_on_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !done);

   assert_step_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && !start) |=> $stable(step));
endmodule

// File: rtl/sign_plane_unit.sv
module sign_plane_unit
   import sign_plane_pkg::*;
#(
   parameter int unsigned LANES     = DEF_LANES,
   parameter int unsigned LANE_W    = DEF_LANE_W,
   parameter int unsigned PIX_LANES = DEF_PIX_LANES,
   localparam int unsigned VEC_W    = LANES * LANE_W,
   localparam int unsigned PIX_W    = PIX_LANES * LANE_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [LANES-1:0]     op_mask,
   input  logic [VEC_W-1:0]     op_vec_in,
   input  logic                 op_fill,
   output logic [VEC_W-1:0]     op_vec_out,
   input  logic                 pl_start,
   input  logic                 pl_valid,
   input  logic [PIX_LANES-1:0] pl_byte,
   output logic                 pl_done,
   output logic [PIX_W-1:0]     pl_pixels
);
   if (PIX_LANES > LANES) begin : g_bad_pix
      $error("sign_plane_unit: PIX_LANES must not exceed LANES");
   end

   fill_mode_e op_mode;
   assign op_mode = fill_mode_e'(op_fill);

   lane_sign_expand #(
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) u_expand (
      .mask    (op_mask),
      .vec_in  (op_vec_in),
      .mode    (op_mode),
      .vec_out (op_vec_out)
   );

   planar_packer #(
      .PIX_LANES (PIX_LANES),
      .LANE_W    (LANE_W)
   ) u_packer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (pl_start),
      .valid  (pl_valid),
      .plane  (pl_byte),
      .done   (pl_done),
      .pixels (pl_pixels)
   );

   function automatic logic [LANES-1:0] sign_bits(input logic [VEC_W-1:0] v);
      for (int i = 0; i < LANES; i++) sign_bits[i] = v[i*LANE_W + LANE_W - 1];
   endfunction

   function automatic logic low_bits_match(input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b);
      low_bits_match = 1'b1;
      for (int i = 0; i < LANES; i++) begin
         if (a[i*LANE_W +: LANE_W-1] != b[i*LANE_W +: LANE_W-1]) low_bits_match = 1'b0;
      end
   endfunction

   assert_sign_from_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
      sign_bits(op_vec_out) == op_mask);

   assert_keep_low_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !op_fill |-> low_bits_match(op_vec_out, op_vec_in));
endmodule

// File: tb/sign_plane_unit_bench.sv
module sign_plane_unit_bench;
   logic         clk = 1'b0;
   logic         rst_n;
   logic [15:0]  op_mask;
   logic [127:0] op_vec_in;
   logic         op_fill;
   logic [127:0] op_vec_out;
   logic         pl_start;
   logic         pl_valid;
   logic [7:0]   pl_byte;
   logic         pl_done;
   logic [63:0]  pl_pixels;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   sign_plane_unit u_sign_plane_unit (
      .clk(clk), .rst_n(rst_n),
      .op_mask(op_mask), .op_vec_in(op_vec_in), .op_fill(op_fill), .op_vec_out(op_vec_out),
      .pl_start(pl_start), .pl_valid(pl_valid), .pl_byte(pl_byte),
      .pl_done(pl_done), .pl_pixels(pl_pixels)
   );

   function automatic logic [127:0] model_op(input logic [15:0] m, input logic [127:0] v, input logic f);
      for (int i = 0; i < 16; i++) begin
         if (f) model_op[i*8 +: 8] = m[i] ? 8'hFF : 8'h00;
         else   model_op[i*8 +: 8] = {m[i], v[i*8 +: 7]};
      end
   endfunction

   function automatic logic [63:0] model_pack(input logic [7:0] p [8]);
      for (int j = 0; j < 8; j++)
         for (int k = 0; k < 8; k++)
            model_pack[j*8 + k] = p[k][j];
   endfunction

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic op_case(input string req, input logic [15:0] m, input logic [127:0] v, input logic f);
      @(negedge clk);
      op_mask = m; op_vec_in = v; op_fill = f;
      #2;
      check(req, op_vec_out, model_op(m, v, f));
   endtask

   task automatic pulse_start();
      @(negedge clk);
      pl_start = 1'b1;
      @(negedge clk);
      pl_start = 1'b0;
   endtask

   task automatic feed(input logic [7:0] b, input int gap);
      for (int g = 0; g < gap; g++) begin
         @(negedge clk);
         pl_valid = 1'b0;
         pl_byte  = $urandom;
      end
      @(negedge clk);
      pl_valid = 1'b1;
      pl_byte  = b;
   endtask

   task automatic convert(input logic [7:0] p [8], input bit gaps, input string req);
      pulse_start();
      check("R4", {64'd0, pl_pixels}, 128'd0);
      for (int k = 0; k < 8; k++) begin
         feed(p[k], gaps ? int'($urandom_range(0, 2)) : 0);
         if (k < 7) begin
            @(negedge clk);
            pl_valid = 1'b0;
            check("R7", {127'd0, pl_done}, 128'd0);
            pl_valid = 1'b0;
         end
      end
      @(negedge clk);
      pl_valid = 1'b0;
      check("R7", {127'd0, pl_done}, 128'd1);
      check(req, {64'd0, pl_pixels}, {64'd0, model_pack(p)});
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin : main
      logic [7:0]  planes [8];
      logic [63:0] held;
      void'($urandom(32'd1234));
      rst_n = 1'b0; op_mask = '0; op_vec_in = '0; op_fill = 1'b0;
      pl_start = 1'b0; pl_valid = 1'b0; pl_byte = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R4 reset", {64'd0, pl_pixels}, 128'd0);
      check("R7 reset", {127'd0, pl_done}, 128'd0);

      op_case("R1", 16'hFFFF, 128'd0, 1'b0);
      op_case("R2", 16'h0000, {16{8'hFF}}, 1'b0);
      op_case("R2", 16'hA5C3, {8{16'h7F80}}, 1'b0);
      op_case("R3", 16'h8001, {16{8'h5A}}, 1'b1);
      op_case("R3", 16'h0000, {16{8'hFF}}, 1'b1);
      for (int n = 0; n < 40; n++)
         op_case(n[0] ? "R3" : "R1 R2", 16'($urandom),
                 {$urandom, $urandom, $urandom, $urandom}, 1'($urandom));

      for (int k = 0; k < 8; k++) planes[k] = 8'h00;
      planes[0] = 8'hFF;
      convert(planes, 1'b0, "R5 plane0");
      for (int k = 0; k < 8; k++) planes[k] = 8'h00;
      planes[7] = 8'h81;
      convert(planes, 1'b0, "R5 plane7");
      for (int k = 0; k < 8; k++) planes[k] = 8'(1 << k);
      convert(planes, 1'b0, "R5 diagonal");

      for (int n = 0; n < 20; n++) begin
         for (int k = 0; k < 8; k++) planes[k] = 8'($urandom);
         convert(planes, n[0], "R5 R6 random");
      end

      held = pl_pixels;
      for (int g = 0; g < 5; g++) begin
         @(negedge clk);
         pl_valid = 1'b1; pl_byte = 8'($urandom);
      end
      @(negedge clk);
      pl_valid = 1'b0;
      check("R8 hold", {64'd0, pl_pixels}, {64'd0, held});
      check("R8 no done", {127'd0, pl_done}, 128'd0);

      pulse_start();
      for (int k = 0; k < 3; k++) feed(8'hFF, 0);
      for (int k = 0; k < 8; k++) planes[k] = 8'($urandom);
      @(negedge clk);
      pl_valid = 1'b1; pl_byte = 8'hFF; pl_start = 1'b1;
      @(negedge clk);
      pl_start = 1'b0; pl_valid = 1'b0;
      check("R9 restart clear", {64'd0, pl_pixels}, 128'd0);
      for (int k = 0; k < 8; k++) begin
         feed(planes[k], 0);
         @(negedge clk);
         pl_valid = 1'b0;
         if (k == 7) check("R9 done", {127'd0, pl_done}, 128'd1);
      end
      check("R9 restart result", {64'd0, pl_pixels}, {64'd0, model_pack(planes)});

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule